// File: doc/BRIEF.md
# Lane Count Reconfiguration Sequencer

This block changes how many transmit lanes of a four-lane serial display PHY are in use. A one-cycle `start` pulse carries the requested lane count (1, 2 or 4). The block then runs a fixed series of 32-bit reads, writes and status polls on a simple register-master port.

During the series the block marks the unused lanes as electrically idle. It steps the per-lane reset bits so that lane 0 and the unused lanes are held in reset before the used lanes are released. It waits for the common block to report ready, then holds a guard delay. After that it turns on the PLL clock of the master lane and walks the configured lanes through two power states.

Every poll has a cycle-count timeout. When a poll times out, the series stops and a sticky error is raised together with `done`. A lane count that is not supported is refused before any register access is made.

Top module: `lane_reconfig_seq`

## Requirements
- R1: A start with a lane count other than 1, 2 or 4, or larger than the physical lane count, is refused. In the cycle after start, `done` and `error` are high and `busy` is low, and no bus access follows.
- R2: The lane mask is 0x1 for one lane, 0x3 for two lanes and 0xF for four lanes. The first access reads the reset-control register. The second access writes the value read back to that register with bits [7:4] (the idle field) replaced by the inverted mask and every other bit unchanged.
- R3: The third access writes the same value to the reset-control register with bit 0 cleared.
- R4: The fourth access writes the reset-control register with bits [31:16] = 0, bits [15:4] taken from the R2 value, and bits [3:0] = 0xE AND mask.
- R5: Next comes a write to the power-request register. Byte i of that write is 0x01 (state A0) for each enabled lane i and 0x00 for the other lanes. A write of 0 to the PLL-clock-enable register follows.
- R6: Next comes a reset-control write with bits [15:4] taken from the R2 value, bits [3:0] = mask, and bits [31:16] = 0.
- R7: The block then reads the status register until bit 0 is 1. After that read it waits a guard time of ceil(GUARD_NS / CLK_PERIOD_NS) cycles, and at least one cycle, before its next request.
- R8: The next access writes 0x00000001 to the PLL-clock-enable register. This is the only nonzero value ever written there.
- R9: The block writes the power-request register with byte value 0x04 (state A2) for each enabled lane. It then polls the power-acknowledge register until that register, masked to the enabled-lane bytes, equals the request. It repeats the write and the poll with 0x01 (A0). `done` pulses for one cycle in the cycle after the last handshake, with `error` low.
- R10: A poll read that fails its condition when at least `timeout_cycles` cycles have passed since the poll began ends the series. `done` and `error` go high and no further access follows. `error` stays high until the next start is accepted, and that start clears it.
- R11: `bus_req` stays high, with `bus_we`, `bus_addr` and `bus_wdata` unchanged, until `bus_ack`. A transfer completes on a clock edge where both are high, and only one transfer is outstanding at a time.
- R12: After reset, `busy`, `done`, `error` and `bus_req` are low. No request is issued while the block is idle. A start while busy has no effect on the series.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, sampled when idle |
| lane_count | input | 3 | Requested number of lanes |
| timeout_cycles | input | TW | Poll timeout in cycles, latched at start |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion or refusal pulse |
| error | output | 1 | Sticky: refusal or poll timeout |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Register address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Access acknowledge |

## Verification
The hardest case to reach from the ports is the poll timeout. It must hit exactly at the common-ready poll, after all the reset-field writes have completed, and it must not leave any write behind. The bench register model never reports ready, so the block keeps polling. The bench then checks three things: the abort cycle falls within a window measured from the last write; the only pending expected access is that poll; and the error stays high until a later valid start clears it. A start that arrives while a run is in progress is also injected, and the expected access sequence of the original lane count must still match.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
   localparam int REG_W     = 32;
   localparam int LANES_MAX = 4;
   localparam logic [7:0] PS_A0 = 8'h01;
   localparam logic [7:0] PS_A2 = 8'h04;

   typedef enum logic [3:0] {
      ST_IDLE, ST_RD_CTRL, ST_WR_IDLE, ST_WR_LINK, ST_WR_HOLD,
      ST_WR_PS_A0, ST_WR_CLK_OFF, ST_WR_REL, ST_POLL_CMN, ST_GUARD,
      ST_WR_CLK_MST, ST_WR_PS_A2, ST_POLL_A2, ST_WR_PS_RUN, ST_POLL_RUN
   } step_e;

   function automatic logic [REG_W-1:0] lane_bytes(input logic [LANES_MAX-1:0] m,
                                                   input logic [7:0] code);
      logic [REG_W-1:0] r;
      r = '0;
      for (int i = 0; i < LANES_MAX; i++)
         if (m[i]) r[i*8 +: 8] = code;
      return r;
   endfunction
endpackage

// File: rtl/lrs_cfg_check.sv
module lrs_cfg_check
   import lrs_pkg::*;
#(
   parameter int NUM_LANES = 4,
   parameter int CW        = 3
) (
   input  logic [CW-1:0]        lane_count,
   output logic                 cfg_ok,
   output logic [LANES_MAX-1:0] lane_mask
);
   localparam logic [CW-1:0] MAX_CNT = CW'(NUM_LANES);

   always_comb begin
      if (lane_count == CW'(1))      lane_mask = 4'h1;
      else if (lane_count == CW'(2)) lane_mask = 4'h3;
      else if (lane_count == CW'(4)) lane_mask = 4'hF;
      else                           lane_mask = 4'h0;
      cfg_ok = (lane_mask != 4'h0) && (lane_count <= MAX_CNT);
   end
endmodule

// File: rtl/lrs_bus_port.sv
module lrs_bus_port
   import lrs_pkg::*;
#(
   parameter int AW = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic             op_we,
   input  logic [AW-1:0]    op_addr,
   input  logic [REG_W-1:0] op_wdata,
   output logic             op_done,
   output logic [REG_W-1:0] op_rdata,
   output logic             bus_req,
   output logic             bus_we,
   output logic [AW-1:0]    bus_addr,
   output logic [REG_W-1:0] bus_wdata,
   input  logic [REG_W-1:0] bus_rdata,
   input  logic             bus_ack
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_req   <= 1'b0;
         bus_we    <= 1'b0;
         bus_addr  <= '0;
         bus_wdata <= '0;
      end else if (bus_req) begin
         if (bus_ack) bus_req <= 1'b0;
      end else if (op_valid) begin
         bus_req   <= 1'b1;
         bus_we    <= op_we;
         bus_addr  <= op_addr;
         bus_wdata <= op_wdata;
      end
   end

   assign op_done  = bus_req & bus_ack;
   assign op_rdata = bus_rdata;
endmodule

// File: rtl/lrs_timer.sv
module lrs_timer #(
   parameter int TW        = 16,
   parameter int GUARD_CYC = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          poll_run,
   input  logic [TW-1:0] limit,
   output logic          poll_expired,
   input  logic          guard_run,
   output logic          guard_done
);
   logic [TW-1:0] pcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            pcnt <= '0;
      else if (!poll_run)    pcnt <= '0;
      else if (pcnt != '1)   pcnt <= pcnt + 1'b1;
   end
   assign poll_expired = (pcnt >= limit);

   generate
      if (GUARD_CYC <= 1) begin : g_single
         assign guard_done = guard_run;
      end else begin : g_count
         localparam int GW = $clog2(GUARD_CYC);
         logic [GW-1:0] gcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         gcnt <= '0;
            else if (!guard_run) gcnt <= '0;
            else                gcnt <= gcnt + 1'b1;
         end
         assign guard_done = guard_run && (gcnt == GW'(GUARD_CYC - 1));
      end
   endgenerate
endmodule

// File: rtl/lrs_seq.sv
module lrs_seq
   import lrs_pkg::*;
#(
   parameter int              AW          = 12,
   parameter int              TW          = 16,
   parameter logic [AW-1:0]   RST_ADDR    = 12'h100,
   parameter logic [AW-1:0]   PLLEN_ADDR  = 12'h104,
   parameter logic [AW-1:0]   PWRREQ_ADDR = 12'h108,
   parameter logic [AW-1:0]   PWRACK_ADDR = 12'h10C,
   parameter logic [AW-1:0]   STAT_ADDR   = 12'h200
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 cfg_ok,
   input  logic [LANES_MAX-1:0] cfg_mask,
   input  logic [TW-1:0]        timeout_cycles,
   output logic                 op_valid,
   output logic                 op_we,
   output logic [AW-1:0]        op_addr,
   output logic [REG_W-1:0]     op_wdata,
   input  logic                 op_done,
   input  logic [REG_W-1:0]     op_rdata,
   output logic                 poll_run,
   output logic [TW-1:0]        limit_q,
   input  logic                 poll_expired,
   output logic                 guard_run,
   input  logic                 guard_done,
   output logic                 busy,
   output logic                 done,
   output logic                 error
);
   step_e                st;
   logic [LANES_MAX-1:0] mask_q;
   logic [REG_W-1:0]     shadow;
   logic [REG_W-1:0]     byte_sel;
   logic [REG_W-1:0]     pat_a0;
   logic [REG_W-1:0]     pat_a2;
   logic                 poll_ok;

   assign byte_sel  = lane_bytes(mask_q, 8'hFF);
   assign pat_a0    = lane_bytes(mask_q, PS_A0);
   assign pat_a2    = lane_bytes(mask_q, PS_A2);
   assign poll_run  = (st == ST_POLL_CMN) || (st == ST_POLL_A2) || (st == ST_POLL_RUN);
   assign guard_run = (st == ST_GUARD);
   assign busy      = (st != ST_IDLE);

   always_comb begin
      op_valid = 1'b1;
      op_we    = 1'b1;
      op_addr  = RST_ADDR;
      op_wdata = '0;
      case (st)
         ST_RD_CTRL:    op_we = 1'b0;
         ST_WR_IDLE:    op_wdata = shadow;
         ST_WR_LINK:    op_wdata = shadow & ~32'h1;
         ST_WR_HOLD:    op_wdata = {16'h0, shadow[15:4], 4'hE & mask_q};
         ST_WR_PS_A0:   begin op_addr = PWRREQ_ADDR; op_wdata = pat_a0; end
         ST_WR_CLK_OFF: op_addr = PLLEN_ADDR;
         ST_WR_REL:     op_wdata = {16'h0, shadow[15:4], mask_q};
         ST_POLL_CMN:   begin op_we = 1'b0; op_addr = STAT_ADDR; end
         ST_WR_CLK_MST: begin op_addr = PLLEN_ADDR; op_wdata = 32'h1; end
         ST_WR_PS_A2:   begin op_addr = PWRREQ_ADDR; op_wdata = pat_a2; end
         ST_POLL_A2:    begin op_we = 1'b0; op_addr = PWRACK_ADDR; end
         ST_WR_PS_RUN:  begin op_addr = PWRREQ_ADDR; op_wdata = pat_a0; end
         ST_POLL_RUN:   begin op_we = 1'b0; op_addr = PWRACK_ADDR; end
         default:       begin op_valid = 1'b0; op_we = 1'b0; end
      endcase
   end

   always_comb begin
      case (st)
         ST_POLL_CMN: poll_ok = op_rdata[0];
         ST_POLL_A2:  poll_ok = ((op_rdata & byte_sel) == pat_a2);
         ST_POLL_RUN: poll_ok = ((op_rdata & byte_sel) == pat_a0);
         default:     poll_ok = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         mask_q  <= '0;
         shadow  <= '0;
         limit_q <= '0;
         done    <= 1'b0;
         error   <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  error <= !cfg_ok;
                  if (cfg_ok) begin
                     st      <= ST_RD_CTRL;
                     mask_q  <= cfg_mask;
                     limit_q <= timeout_cycles;
                  end else begin
                     done <= 1'b1;
                  end
               end
            end
            ST_GUARD: if (guard_done) st <= ST_WR_CLK_MST;
            default: begin
               if (op_done) begin
                  if (poll_run) begin
                     if (poll_ok) begin
                        if (st == ST_POLL_RUN) begin
                           st   <= ST_IDLE;
                           done <= 1'b1;
                        end else begin
                           st <= step_e'(st + 4'd1);
                        end
                     end else if (poll_expired) begin
                        st    <= ST_IDLE;
                        done  <= 1'b1;
                        error <= 1'b1;
                     end
                  end else begin
                     if (st == ST_RD_CTRL)
                        shadow <= (op_rdata & ~32'hF0) | {24'h0, ~mask_q, 4'h0};
                     st <= step_e'(st + 4'd1);
                  end
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/lane_reconfig_seq.sv
module lane_reconfig_seq
   import lrs_pkg::*;
#(
   parameter int            NUM_LANES     = 4,
   parameter int            AW            = 12,
   parameter int            TW            = 16,
   parameter int            CLK_PERIOD_NS = 20,
   parameter int            GUARD_NS      = 100,
   parameter logic [AW-1:0] RST_ADDR      = 12'h100,
   parameter logic [AW-1:0] PLLEN_ADDR    = 12'h104,
   parameter logic [AW-1:0] PWRREQ_ADDR   = 12'h108,
   parameter logic [AW-1:0] PWRACK_ADDR   = 12'h10C,
   parameter logic [AW-1:0] STAT_ADDR     = 12'h200
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [2:0]       lane_count,
   input  logic [TW-1:0]    timeout_cycles,
   output logic             busy,
   output logic             done,
   output logic             error,
   output logic             bus_req,
   output logic             bus_we,
   output logic [AW-1:0]    bus_addr,
   output logic [REG_W-1:0] bus_wdata,
   input  logic [REG_W-1:0] bus_rdata,
   input  logic             bus_ack
);
   localparam int GUARD_RAW = (GUARD_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
   localparam int GUARD_CYC = (GUARD_RAW < 1) ? 1 : GUARD_RAW;

   generate
      if (!(NUM_LANES == 1 || NUM_LANES == 2 || NUM_LANES == 4)) begin : g_bad_lanes
         $error("NUM_LANES must be 1, 2 or 4");
      end
      if (TW < 1 || CLK_PERIOD_NS < 1 || GUARD_NS < 0) begin : g_bad_time
         $error("timing parameters out of range");
      end
   endgenerate

   logic                 cfg_ok;
   logic [LANES_MAX-1:0] cfg_mask;
   logic                 op_valid, op_we, op_done;
   logic [AW-1:0]        op_addr;
   logic [REG_W-1:0]     op_wdata, op_rdata;
   logic                 poll_run, poll_expired, guard_run, guard_done;
   logic [TW-1:0]        limit_q;

   lrs_cfg_check #(.NUM_LANES(NUM_LANES), .CW(3)) u_cfg (
      .lane_count(lane_count), .cfg_ok(cfg_ok), .lane_mask(cfg_mask));

   lrs_seq #(
      .AW(AW), .TW(TW), .RST_ADDR(RST_ADDR), .PLLEN_ADDR(PLLEN_ADDR),
      .PWRREQ_ADDR(PWRREQ_ADDR), .PWRACK_ADDR(PWRACK_ADDR), .STAT_ADDR(STAT_ADDR)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_ok(cfg_ok), .cfg_mask(cfg_mask),
      .timeout_cycles(timeout_cycles), .op_valid(op_valid), .op_we(op_we),
      .op_addr(op_addr), .op_wdata(op_wdata), .op_done(op_done), .op_rdata(op_rdata),
      .poll_run(poll_run), .limit_q(limit_q), .poll_expired(poll_expired),
      .guard_run(guard_run), .guard_done(guard_done),
      .busy(busy), .done(done), .error(error));

   lrs_bus_port #(.AW(AW)) u_port (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_we(op_we), .op_addr(op_addr),
      .op_wdata(op_wdata), .op_done(op_done), .op_rdata(op_rdata),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ack(bus_ack));

   lrs_timer #(.TW(TW), .GUARD_CYC(GUARD_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .poll_run(poll_run), .limit(limit_q),
      .poll_expired(poll_expired), .guard_run(guard_run), .guard_done(guard_done));
endmodule

// File: rtl/lrs_chk.sv
module lrs_chk #(
   parameter int            AW         = 12,
   parameter int            NUM_LANES  = 4,
   parameter logic [AW-1:0] RST_ADDR   = 12'h100,
   parameter logic [AW-1:0] PLLEN_ADDR = 12'h104
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [2:0]    lane_count,
   input logic          busy,
   input logic          done,
   input logic          error,
   input logic          bus_req,
   input logic          bus_we,
   input logic [AW-1:0] bus_addr,
   input logic [31:0]   bus_wdata,
   input logic          bus_ack
);
   logic       ck_ok;
   logic [3:0] ck_m, mask_q;

   always_comb begin
      case (lane_count)
         3'd1:    ck_m = 4'h1;
         3'd2:    ck_m = 4'h3;
         3'd4:    ck_m = 4'hF;
         default: ck_m = 4'h0;
      endcase
      ck_ok = (ck_m != 4'h0) && (lane_count <= 3'(NUM_LANES));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= 4'h0;
      else if (start && !busy && ck_ok) mask_q <= ck_m;
   end

   AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && !ck_ok |=> done && error && !bus_req); // R1
   AST_IDLE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_we && (bus_addr == RST_ADDR) |-> bus_wdata[7:4] == ~mask_q); // R2
   AST_PLL_CODES: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_we && (bus_addr == PLLEN_ADDR) |-> bus_wdata == 32'h0 || bus_wdata == 32'h1); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      error && !start |=> error); // R10
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)); // R11
   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_req); // R12
endmodule

bind lane_reconfig_seq lrs_chk #(
   .AW(AW), .NUM_LANES(NUM_LANES), .RST_ADDR(RST_ADDR), .PLLEN_ADDR(PLLEN_ADDR)
) u_lrs_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .lane_count(lane_count), .busy(busy),
   .done(done), .error(error), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .bus_ack(bus_ack));

// File: tb/test_lane_reconfig_seq.sv
`timescale 1ns/1ps
module test_lane_reconfig_seq;
   localparam logic [11:0] A_RST = 12'h100, A_PLL = 12'h104, A_PWR = 12'h108,
                           A_ACK = 12'h10C, A_STAT = 12'h200;
   localparam int GC = (100 + 19) / 20;

   typedef struct packed {
      logic [1:0]  kind;   // 0 plain, 1 status poll, 2 power-ack poll
      logic        we;
      logic [11:0] addr;
      logic [31:0] data;
   } exp_t;

   logic clk = 0, rst_n = 0, start = 0, bus_ack = 0;
   logic [2:0] lane_count = 0;
   logic [15:0] timeout_cycles = 16'd2000;
   logic busy, done, error, bus_req, bus_we;
   logic [11:0] bus_addr;
   logic [31:0] bus_wdata, bus_rdata = 0;

   int compared = 0, mismatched = 0, cyc = 0;
   exp_t q[$];
   string tq[$];
   string ctx = "R12";
   int lat = 0, wcnt = 0, cmn_need = 0, ack_need = 0, cmn_reads = 0, ack_reads = 0;
   int seen_cyc = 0, guard_seen = -1, cmn_ok_cyc = -1, last_wr_cyc = 0, last_srv_cyc = 0;
   logic [31:0] rst_reg = 0, pwr_reg = 0;
   logic [3:0] cur_mask = 0;

   lane_reconfig_seq i_lane_reconfig_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .lane_count(lane_count),
      .timeout_cycles(timeout_cycles), .busy(busy), .done(done), .error(error),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ack(bus_ack));

   always #10 clk = ~clk;
   always @(posedge clk) cyc++;

   task automatic chk(input bit ok, input string r, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
      end
   endtask

   function automatic logic [31:0] bpat(input logic [3:0] m, input logic [7:0] c);
      logic [31:0] r = 0;
      for (int i = 0; i < 4; i++) if (m[i]) r[i*8 +: 8] = c;
      return r;
   endfunction

   task automatic push(input logic [1:0] k, input logic w, input logic [11:0] a,
                       input logic [31:0] d, input string r);
      exp_t e;
      e.kind = k; e.we = w; e.addr = a; e.data = d;
      q.push_back(e); tq.push_back(r);
   endtask

   // register model of the PHY and comparison of each access
   task automatic serve();
      exp_t h;
      logic [31:0] rd = 32'h0;
      if (q.size() == 0) begin
         chk(0, ctx, "unexpected access addr", {20'h0, bus_addr}, 32'h0);
         bus_rdata = 0;
         return;
      end
      h = q[0];
      chk(bus_we === h.we && bus_addr === h.addr && (!h.we || bus_wdata === h.data),
          tq[0], "access", bus_we ? bus_wdata : {20'h0, bus_addr},
          h.we ? h.data : {20'h0, h.addr});
      if (bus_we) begin
         if (bus_addr == A_RST) rst_reg = bus_wdata;
         if (bus_addr == A_PWR) begin pwr_reg = bus_wdata; ack_reads = 0; end
         last_wr_cyc = cyc;
      end else if (bus_addr == A_RST) rd = rst_reg;
      else if (bus_addr == A_STAT) begin
         rd = (cmn_reads >= cmn_need) ? 32'h0000_0F01 : 32'h0000_0F00;
         cmn_reads++;
      end else if (bus_addr == A_ACK) begin
         ack_reads++;
         rd = (~bpat(cur_mask, 8'hFF) & 32'h5A5A5A5A);
         if (ack_reads > ack_need) rd = rd | pwr_reg;
      end
      bus_rdata = rd;
      last_srv_cyc = cyc;
      if (h.kind == 0) begin
         if (h.we && h.addr == A_PLL && h.data == 32'h1) guard_seen = seen_cyc;
         void'(q.pop_front()); void'(tq.pop_front());
      end else if (h.kind == 1 && rd[0]) begin
         cmn_ok_cyc = cyc;
         void'(q.pop_front()); void'(tq.pop_front());
      end else if (h.kind == 2 && (rd & bpat(cur_mask, 8'hFF)) == h.data) begin
         void'(q.pop_front()); void'(tq.pop_front());
      end
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin bus_ack = 0; wcnt = 0; end
      else if (bus_ack) begin bus_ack = 0; wcnt = 0; end
      else if (bus_req) begin
         if (wcnt == 0) seen_cyc = cyc;
         if (wcnt < lat) wcnt++;
         else begin serve(); bus_ack = 1; end
      end
   end

   task automatic build(input int lanes, input logic [31:0] init);
      logic [3:0] m;
      logic [31:0] v1;
      m = (lanes == 1) ? 4'h1 : (lanes == 2) ? 4'h3 : 4'hF;
      cur_mask = m;
      v1 = (init & ~32'hF0) | {24'h0, ~m, 4'h0};
      q.delete(); tq.delete();
      push(0, 0, A_RST, 0, "R2");
      push(0, 1, A_RST, v1, "R2");
      push(0, 1, A_RST, v1 & ~32'h1, "R3");
      push(0, 1, A_RST, {16'h0, v1[15:4], 4'hE & m}, "R4");
      push(0, 1, A_PWR, bpat(m, 8'h01), "R5");
      push(0, 1, A_PLL, 0, "R5");
      push(0, 1, A_RST, {16'h0, v1[15:4], m}, "R6");
      push(1, 0, A_STAT, 1, "R7");
      push(0, 1, A_PLL, 1, "R8");
      push(0, 1, A_PWR, bpat(m, 8'h04), "R9");
      push(2, 0, A_ACK, bpat(m, 8'h04), "R9");
      push(0, 1, A_PWR, bpat(m, 8'h01), "R9");
      push(2, 0, A_ACK, bpat(m, 8'h01), "R9");
   endtask

   task automatic setup(input int lanes, input logic [31:0] init, input int l,
                        input int cn, input int an);
      lat = l; cmn_need = cn; ack_need = an; cmn_reads = 0; ack_reads = 0;
      rst_reg = init; guard_seen = -1; cmn_ok_cyc = -1;
      build(lanes, init);
   endtask

   task automatic run_ok(input int lanes, input logic [31:0] init, input int l,
                         input int cn, input int an, input bit inject);
      int n = 0;
      setup(lanes, init, l, cn, an);
      ctx = "R11";
      @(negedge clk); start = 1; lane_count = 3'(lanes); timeout_cycles = 16'd2000;
      @(negedge clk); start = 0;
      chk(busy == 1 && error == 0, "R10", "busy/error after accepted start",
          {30'h0, busy, error}, 32'h2);
      while (!done && n < 5000) begin
         @(negedge clk); n++;
         if (inject && n == 8) begin start = 1; lane_count = 3'd1; end   // R12
         else start = 0;
      end
      chk(done == 1 && error == 0, "R9", "done without error",
          {30'h0, done, error}, 32'h2);
      chk(q.size() == 0, "R9", "expected accesses left", q.size(), 0);
      chk(cyc == last_srv_cyc + 1, "R9", "done cycle", cyc, last_srv_cyc + 1);
      chk(guard_seen - cmn_ok_cyc == GC + 2, "R7", "guard gap",
          guard_seen - cmn_ok_cyc, GC + 2);
      @(negedge clk);
      chk(done == 0 && busy == 0, "R12", "idle after done", {30'h0, done, busy}, 0);
   endtask

   task automatic run_reject(input int lanes);
      q.delete(); tq.delete(); ctx = "R1";
      @(negedge clk); start = 1; lane_count = 3'(lanes);
      @(negedge clk); start = 0;
      chk(done == 1 && error == 1 && busy == 0, "R1", "refusal flags",
          {29'h0, done, error, busy}, 32'h6);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk(bus_req == 0, "R1", "no access after refusal", bus_req, 0);
      end
   endtask

   task automatic run_timeout(input int tmo);
      int n = 0, d;
      setup(2, 32'h0000_A5F0, 0, 1000000, 0);
      ctx = "R10";
      @(negedge clk); start = 1; lane_count = 3'd2; timeout_cycles = 16'(tmo);
      @(negedge clk); start = 0;
      while (!done && n < 5000) begin @(negedge clk); n++; end
      d = cyc;
      chk(done == 1 && error == 1, "R10", "timeout flags", {30'h0, done, error}, 32'h3);
      chk(q.size() > 0 && q[0].kind == 1, "R10", "stopped at status poll",
          q.size() > 0 ? q[0].kind : 2'd3, 1);
      chk(d - (last_wr_cyc + 1) >= tmo && d - (last_wr_cyc + 1) <= tmo + 2, "R10",
          "abort cycle window", d - (last_wr_cyc + 1), tmo);
      for (int i = 0; i < 6; i++) @(negedge clk);
      chk(error == 1 && busy == 0 && bus_req == 0, "R10", "sticky error, idle",
          {29'h0, error, busy, bus_req}, 32'h4);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(busy == 0 && done == 0 && error == 0 && bus_req == 0, "R12", "reset state",
          {28'h0, busy, done, error, bus_req}, 0);
      run_ok(4, 32'h1234_5678, 0, 2, 1, 0);
      run_ok(1, 32'hFFFF_FF0F, 2, 0, 0, 0);
      run_ok(2, 32'h8000_00A3, 1, 3, 2, 0);
      run_reject(3);
      run_reject(0);
      run_reject(7);
      run_timeout(10);
      run_ok(4, 32'h0F0F_0F0F, 0, 1, 1, 1);   // R12 start while busy, clears error (R10)
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      wait (cyc > 150000);
      chk(0, "R12", "watchdog expired", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule